// File: doc/BRIEF.md
# Single-to-Half Precision Float Converter

This block turns a 32-bit binary floating-point operand into a 16-bit half-width result. It classifies the operand and rounds its significand to nearest, with ties going to even. It packs the result in one of two half-width encodings. The first is the standard encoding. The second gives up infinities and NaNs, so that the all-ones exponent stands for one more binade of ordinary numbers. A separate control forces every NaN that arrives in standard mode to a single canonical NaN pattern.

Each accepted operand produces its result one clock later. The result comes with four per-result exception indications: invalid, overflow, underflow and inexact. The result registers load only on cycles where the input is marked valid. Between operands the output word and the flags hold their last value, while the output valid strobe drops.

Top module: `sp2hp_convert`

## Requirements
- R1: When `in_valid` is high at a rising clock edge, `out_valid` is high after that edge and `out_data`/flags carry that operand's result. When `in_valid` is low, `out_valid` goes low and `out_data` and the flags keep their previous value. After reset all outputs read zero.
- R2: The operand layout is sign in bit 31, biased exponent (bias 127) in bits 30:23 and fraction in bits 22:0. An operand counts as zero only when its exponent and fraction fields are both zero. A zero gives a zero of the same sign (0x0000 or 0x8000) with no flags.
- R3: The result layout is sign in bit 15, exponent (bias 15) in bits 14:10 and mantissa in bits 9:0. For results in the normal range, the 13 low bits of the 24-bit significand (hidden bit restored) are discarded. The kept part is rounded to nearest-even, and a mantissa carry bumps the exponent. Any nonzero discarded bit sets inexact.
- R4: For an unbiased exponent E from -24 to -15, the result is subnormal and 13+(-14-E) low significand bits are discarded, with the same rounding. Rounding may reach 0x0400. Underflow is set when the operand is tiny (E < -14) and the result is inexact.
- R5: For E below -24 the whole significand is discarded. At E = -25 a value above half of the smallest subnormal rounds up to 0x0001, and exactly half rounds to zero. Anything smaller gives a signed zero. All of these set inexact and underflow.
- R6: In standard mode a rounded exponent above 15 gives a signed infinity (exponent 0x1F, mantissa 0) and sets overflow and inexact.
- R7: In the alternative mode (`alt_fmt`=1) rounded exponents up to 16 encode normally, using exponent field 0x1F. Above 16 the result is the signed maximum (exponent 0x1F, mantissa 0x3FF) with invalid and inexact set. Overflow is never set in this mode.
- R8: In standard mode an infinite operand (exponent 0xFF, fraction 0) gives a signed infinity and no flags.
- R9: In the alternative mode an infinite operand gives the signed maximum magnitude and sets invalid only.
- R10: In standard mode a NaN (exponent 0xFF, fraction nonzero) gives sign, exponent 0x1F and mantissa equal to fraction bits 22:13. If those ten bits are zero, the result is the canonical NaN 0x7E00.
- R11: With `dflt_nan`=1 every NaN in standard mode yields 0x7E00. The control has no effect on non-NaN operands or in the alternative mode.
- R12: In the alternative mode a NaN yields a zero with the operand's sign. In both modes a signaling NaN (fraction bit 22 = 0) sets invalid, and a quiet NaN sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operand present this cycle |
| in_data | input | 32 | Single-precision operand |
| alt_fmt | input | 1 | 1 selects the alternative half encoding |
| dflt_nan | input | 1 | 1 forces NaN results to the canonical NaN (standard mode) |
| out_valid | output | 1 | Result presented this cycle |
| out_data | output | 16 | Half-width result |
| flag_invalid | output | 1 | Invalid operation for this result |
| flag_overflow | output | 1 | Overflow for this result |
| flag_underflow | output | 1 | Underflow for this result |
| flag_inexact | output | 1 | Inexact for this result |

## Verification
The bench targets the rounding seams. These are exact ties with an even and an odd kept bit, a carry that rolls the mantissa into the next binade, and the subnormal that rounds up into 0x0400. A wrong sticky or guard position would show up there as a result one unit off or a missing inexact flag. The bench also covers the E = -25 half-ulp tie and operands far below it, where a design that keeps the hidden bit or skips tie-to-even returns 0x0001 instead of zero. The overflow point at 65520 and the extra binade of the alternative mode are checked too, because a design with a single exponent limit either saturates too early or reports overflow where invalid belongs. Finally the NaN paths are driven with zero and nonzero payloads, with the default-NaN control in both modes, and with signaling operands, so that payload loss or a misplaced invalid flag shows up.

// File: rtl/sp2hp_pkg.sv
package sp2hp_pkg;

  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = 23;
  localparam int SP_W      = 1 + SP_EXP_W + SP_FRAC_W;
  localparam int SP_BIAS   = (1 << (SP_EXP_W - 1)) - 1;

  localparam int HP_EXP_W  = 5;
  localparam int HP_MANT_W = 10;
  localparam int HP_W      = 1 + HP_EXP_W + HP_MANT_W;
  localparam int HP_BIAS   = (1 << (HP_EXP_W - 1)) - 1;

  // significand with hidden bit, bits dropped in the normal range
  localparam int SIG_W     = SP_FRAC_W + 1;
  localparam int DROP_NORM = SP_FRAC_W - HP_MANT_W;
  // one guard position above the significand for the deepest shift
  localparam int XSIG_W    = SIG_W + 1;
  localparam int DROP_W    = $clog2(XSIG_W + 1);
  localparam int UEXP_W    = SP_EXP_W + 2;

  localparam int EMIN_NORM = 1 - HP_BIAS;                 // -14
  localparam int EMIN_SUB  = EMIN_NORM - HP_MANT_W;       // -24
  localparam int EMAX_STD  = HP_BIAS;                     // 15
  localparam int EMAX_ALT  = HP_BIAS + 1;                 // 16

  localparam logic [HP_W-2:0] MAG_INF  = {{HP_EXP_W{1'b1}}, {HP_MANT_W{1'b0}}};
  localparam logic [HP_W-2:0] MAG_MAX  = {HP_EXP_W + HP_MANT_W{1'b1}};
  localparam logic [HP_W-1:0] CANON_NAN =
    {1'b0, {HP_EXP_W{1'b1}}, 1'b1, {HP_MANT_W-1{1'b0}}};

  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_FINITE,
    CLS_INF,
    CLS_QNAN,
    CLS_SNAN
  } in_class_e;

  typedef struct packed {
    logic invalid;
    logic overflow;
    logic underflow;
    logic inexact;
  } exc_flags_t;

endpackage

// File: rtl/sp2hp_rst_sync.sv
module sp2hp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/sp2hp_classify.sv
module sp2hp_classify
  import sp2hp_pkg::*;
(
  input  logic [SP_W-1:0]          op,
  output in_class_e                cls,
  output logic                     sign,
  output logic signed [UEXP_W-1:0] unb_exp,
  output logic [SIG_W-1:0]         sig,
  output logic [HP_MANT_W-1:0]     payload
);

  logic [SP_EXP_W-1:0]  exp_f;
  logic [SP_FRAC_W-1:0] frac_f;
  logic                 exp_ones;
  logic                 exp_zero;
  logic                 frac_zero;

  assign sign   = op[SP_W-1];
  assign exp_f  = op[SP_W-2 -: SP_EXP_W];
  assign frac_f = op[SP_FRAC_W-1:0];

  assign exp_ones  = &exp_f;
  assign exp_zero  = ~|exp_f;
  assign frac_zero = ~|frac_f;

  always_comb begin
    if (exp_ones && frac_zero)       cls = CLS_INF;
    else if (exp_ones)               cls = frac_f[SP_FRAC_W-1] ? CLS_QNAN : CLS_SNAN;
    else if (exp_zero && frac_zero)  cls = CLS_ZERO;
    else                             cls = CLS_FINITE;
  end

  // hidden bit restored unconditionally; single subnormals land far below
  // the half range and only contribute to the sticky bit
  assign sig     = {1'b1, frac_f};
  assign unb_exp = $signed({2'b00, exp_f}) - UEXP_W'(SP_BIAS);
  assign payload = frac_f[SP_FRAC_W-1 -: HP_MANT_W];

endmodule

// File: rtl/sp2hp_round.sv
module sp2hp_round
  import sp2hp_pkg::*;
(
  input  logic signed [UEXP_W-1:0] unb_exp,
  input  logic [SIG_W-1:0]         sig,
  output logic signed [UEXP_W-1:0] rnd_exp,
  output logic [HP_W-2:0]          rnd_field,
  output logic                     rnd_inexact,
  output logic                     tiny
);

  localparam int KEEP_W = HP_MANT_W + 2;

  logic [XSIG_W-1:0] xsig;
  logic [DROP_W-1:0] drop_n;
  logic [KEEP_W-1:0] kept;
  logic [KEEP_W-1:0] rounded;
  logic [XSIG_W-1:0] below_mask;
  logic              half_bit;
  logic              sticky;
  logic              round_up;
  logic              carry;
  logic [HP_EXP_W-1:0] norm_exp;

  assign xsig = {1'b0, sig};
  assign tiny = (unb_exp < UEXP_W'(EMIN_NORM));

  // number of low significand bits that leave the result
  always_comb begin
    if (!tiny)
      drop_n = DROP_W'(DROP_NORM);
    else if (unb_exp < UEXP_W'(EMIN_SUB - 1))
      drop_n = DROP_W'(XSIG_W);
    else
      drop_n = DROP_W'(-UEXP_W'(1) - unb_exp);
  end

  assign kept       = KEEP_W'(xsig >> drop_n);
  assign half_bit   = xsig[DROP_W'(drop_n - DROP_W'(1))];
  assign below_mask = (XSIG_W'(1) << (drop_n - DROP_W'(1))) - XSIG_W'(1);
  assign sticky     = |(xsig & below_mask);

  assign round_up    = half_bit && (sticky || kept[0]);
  assign rnd_inexact = half_bit || sticky;
  assign rounded     = kept + KEEP_W'(round_up);
  assign carry       = rounded[KEEP_W-1];

  assign rnd_exp  = unb_exp + UEXP_W'(carry);
  assign norm_exp = HP_EXP_W'(rnd_exp + UEXP_W'(HP_BIAS));

  always_comb begin
    if (tiny)
      // subnormal: a carry out of the mantissa lands in the exponent field
      rnd_field = (HP_W-1)'(rounded);
    else
      rnd_field = {norm_exp, rounded[HP_MANT_W-1:0]};
  end

endmodule

// File: rtl/sp2hp_pack.sv
module sp2hp_pack
  import sp2hp_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     vld,
  input  logic                     alt,
  input  logic                     dn,
  input  in_class_e                cls,
  input  logic                     sign,
  input  logic [HP_MANT_W-1:0]     payload,
  input  logic signed [UEXP_W-1:0] rnd_exp,
  input  logic [HP_W-2:0]          rnd_field,
  input  logic                     rnd_inexact,
  input  logic                     tiny,
  output logic [HP_W-1:0]          res,
  output exc_flags_t               flags
);

  logic nan_fwd;

  assign nan_fwd = !dn && (payload != '0);

  always_comb begin
    res   = '0;
    flags = '0;
    unique case (cls)
      CLS_ZERO: begin
        res = {sign, {HP_W-1{1'b0}}};
      end
      CLS_INF: begin
        if (alt) begin
          res           = {sign, MAG_MAX};
          flags.invalid = 1'b1;
        end else begin
          res = {sign, MAG_INF};
        end
      end
      CLS_QNAN, CLS_SNAN: begin
        flags.invalid = (cls == CLS_SNAN);
        if (alt)          res = {sign, {HP_W-1{1'b0}}};
        else if (nan_fwd) res = {sign, {HP_EXP_W{1'b1}}, payload};
        else              res = CANON_NAN;
      end
      default: begin
        if (!alt && rnd_exp > UEXP_W'(EMAX_STD)) begin
          res            = {sign, MAG_INF};
          flags.overflow = 1'b1;
          flags.inexact  = 1'b1;
        end else if (alt && rnd_exp > UEXP_W'(EMAX_ALT)) begin
          res           = {sign, MAG_MAX};
          flags.invalid = 1'b1;
          flags.inexact = 1'b1;
        end else begin
          res             = {sign, rnd_field};
          flags.inexact   = rnd_inexact;
          flags.underflow = tiny && rnd_inexact;
        end
      end
    endcase
  end

  AST_ALT_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && alt) |-> !flags.overflow); // R7

  AST_UNDERFLOW_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && flags.underflow) |-> flags.inexact); // R4

  AST_OVERFLOW_IS_INF: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && flags.overflow) |-> (res[HP_W-2:0] == MAG_INF)); // R6

  AST_ZERO_SIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && cls == CLS_ZERO) |-> (res == {sign, {HP_W-1{1'b0}}} && flags == '0)); // R2

  AST_STD_INF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !alt && cls == CLS_INF) |-> (flags == '0)); // R8

  AST_QNAN_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && cls == CLS_QNAN) |-> (flags == '0)); // R12

endmodule

// File: rtl/sp2hp_convert.sv
module sp2hp_convert
  import sp2hp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     in_data,
  input  logic            alt_fmt,
  input  logic            dflt_nan,
  output logic            out_valid,
  output logic [15:0]     out_data,
  output logic            flag_invalid,
  output logic            flag_overflow,
  output logic            flag_underflow,
  output logic            flag_inexact
);

  logic                     rst_sync_n;
  in_class_e                cls;
  logic                     sign;
  logic signed [UEXP_W-1:0] unb_exp;
  logic [SIG_W-1:0]         sig;
  logic [HP_MANT_W-1:0]     payload;
  logic signed [UEXP_W-1:0] rnd_exp;
  logic [HP_W-2:0]          rnd_field;
  logic                     rnd_inexact;
  logic                     tiny;
  logic [HP_W-1:0]          res_c;
  exc_flags_t               flags_c;

  logic                     valid_d, valid_q;
  logic [HP_W-1:0]          res_d, res_q;
  exc_flags_t               flags_d, flags_q;

  sp2hp_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sp2hp_classify u_classify (
    .op      (in_data),
    .cls     (cls),
    .sign    (sign),
    .unb_exp (unb_exp),
    .sig     (sig),
    .payload (payload)
  );

  sp2hp_round u_round (
    .unb_exp     (unb_exp),
    .sig         (sig),
    .rnd_exp     (rnd_exp),
    .rnd_field   (rnd_field),
    .rnd_inexact (rnd_inexact),
    .tiny        (tiny)
  );

  sp2hp_pack u_pack (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .vld         (in_valid),
    .alt         (alt_fmt),
    .dn          (dflt_nan),
    .cls         (cls),
    .sign        (sign),
    .payload     (payload),
    .rnd_exp     (rnd_exp),
    .rnd_field   (rnd_field),
    .rnd_inexact (rnd_inexact),
    .tiny        (tiny),
    .res         (res_c),
    .flags       (flags_c)
  );

  // next state: result registers enabled by in_valid
  always_comb begin
    valid_d = in_valid;
    res_d   = res_q;
    flags_d = flags_q;
    if (in_valid) begin
      res_d   = res_c;
      flags_d = flags_c;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      flags_q <= '0;
    end else begin
      valid_q <= valid_d;
      res_q   <= res_d;
      flags_q <= flags_d;
    end
  end

  assign out_valid      = valid_q;
  assign out_data       = res_q;
  assign flag_invalid   = flags_q.invalid;
  assign flag_overflow  = flags_q.overflow;
  assign flag_underflow = flags_q.underflow;
  assign flag_inexact   = flags_q.inexact;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid); // R1

  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid); // R1

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> ($stable(out_data) && $stable(flag_inexact) && $stable(flag_invalid))); // R1

endmodule

// File: tb/sp2hp_convert_tb_top.sv
module sp2hp_convert_tb_top;

  localparam int CLK_HALF = 10;        // 50 MHz
  localparam int WATCHDOG = 200000;
  localparam int NV       = 42;

  // {tag[7:0], alt, dn, operand[31:0], result[15:0], flags{inv,ovf,unf,inx}}
  localparam logic [61:0] VEC [NV] = '{
    {8'd3,  1'b0, 1'b0, 32'h3F800000, 16'h3C00, 4'h0}, // R3 one
    {8'd3,  1'b0, 1'b0, 32'hC0000000, 16'hC000, 4'h0}, // R3 minus two
    {8'd3,  1'b0, 1'b0, 32'h3F801000, 16'h3C00, 4'h1}, // R3 tie, even kept
    {8'd3,  1'b0, 1'b0, 32'h3F803000, 16'h3C02, 4'h1}, // R3 tie, odd kept
    {8'd3,  1'b0, 1'b0, 32'h3F801001, 16'h3C01, 4'h1}, // R3 above half
    {8'd3,  1'b0, 1'b0, 32'h3FFFF000, 16'h4000, 4'h1}, // R3 mantissa carry
    {8'd6,  1'b0, 1'b0, 32'h477FE000, 16'h7BFF, 4'h0}, // R6 largest finite
    {8'd6,  1'b0, 1'b0, 32'h477FF000, 16'h7C00, 4'h5}, // R6 rounds into overflow
    {8'd7,  1'b1, 1'b0, 32'h477FF000, 16'h7C00, 4'h1}, // R7 extra binade
    {8'd7,  1'b1, 1'b0, 32'h47FFE000, 16'h7FFF, 4'h0}, // R7 alt largest
    {8'd7,  1'b1, 1'b0, 32'h48000000, 16'h7FFF, 4'h9}, // R7 saturate
    {8'd7,  1'b1, 1'b0, 32'hC8000000, 16'hFFFF, 4'h9}, // R7 saturate negative
    {8'd6,  1'b0, 1'b0, 32'h47800000, 16'h7C00, 4'h5}, // R6 exponent 16
    {8'd6,  1'b0, 1'b0, 32'hC7800000, 16'hFC00, 4'h5}, // R6 negative
    {8'd4,  1'b0, 1'b0, 32'h38800000, 16'h0400, 4'h0}, // R4 min normal
    {8'd4,  1'b0, 1'b0, 32'h38000000, 16'h0200, 4'h0}, // R4 exact subnormal
    {8'd4,  1'b0, 1'b0, 32'h33800000, 16'h0001, 4'h0}, // R4 min subnormal
    {8'd4,  1'b0, 1'b0, 32'h33C00000, 16'h0002, 4'h3}, // R4 tie odd
    {8'd4,  1'b0, 1'b0, 32'h33A00000, 16'h0001, 4'h3}, // R4 below half
    {8'd4,  1'b0, 1'b0, 32'h387FFFFF, 16'h0400, 4'h3}, // R4 rounds to normal
    {8'd5,  1'b0, 1'b0, 32'h33000000, 16'h0000, 4'h3}, // R5 half ulp tie
    {8'd5,  1'b0, 1'b0, 32'h33000001, 16'h0001, 4'h3}, // R5 just above half
    {8'd5,  1'b0, 1'b0, 32'hB0800000, 16'h8000, 4'h3}, // R5 far below
    {8'd5,  1'b0, 1'b0, 32'h00000001, 16'h0000, 4'h3}, // R5 single subnormal
    {8'd2,  1'b0, 1'b0, 32'h00000000, 16'h0000, 4'h0}, // R2 plus zero
    {8'd2,  1'b0, 1'b0, 32'h80000000, 16'h8000, 4'h0}, // R2 minus zero
    {8'd8,  1'b0, 1'b0, 32'h7F800000, 16'h7C00, 4'h0}, // R8
    {8'd8,  1'b0, 1'b0, 32'hFF800000, 16'hFC00, 4'h0}, // R8
    {8'd9,  1'b1, 1'b0, 32'h7F800000, 16'h7FFF, 4'h8}, // R9
    {8'd9,  1'b1, 1'b0, 32'hFF800000, 16'hFFFF, 4'h8}, // R9
    {8'd10, 1'b0, 1'b0, 32'h7FC00000, 16'h7E00, 4'h0}, // R10 quiet
    {8'd10, 1'b0, 1'b0, 32'hFFC12000, 16'hFE09, 4'h0}, // R10 payload kept
    {8'd10, 1'b0, 1'b0, 32'h7F802000, 16'h7C01, 4'h8}, // R10 signaling payload
    {8'd10, 1'b0, 1'b0, 32'h7F800001, 16'h7E00, 4'h8}, // R10 empty payload
    {8'd11, 1'b0, 1'b1, 32'hFFC12000, 16'h7E00, 4'h0}, // R11
    {8'd11, 1'b0, 1'b1, 32'h7F802000, 16'h7E00, 4'h8}, // R11 signaling
    {8'd11, 1'b0, 1'b1, 32'h3F800000, 16'h3C00, 4'h0}, // R11 no effect
    {8'd11, 1'b1, 1'b1, 32'hFFC00000, 16'h8000, 4'h0}, // R11 no effect alt
    {8'd12, 1'b1, 1'b0, 32'hFFC00000, 16'h8000, 4'h0}, // R12 quiet
    {8'd12, 1'b1, 1'b0, 32'h7F800001, 16'h0000, 4'h8}, // R12 signaling
    {8'd7,  1'b1, 1'b0, 32'h3F800000, 16'h3C00, 4'h0}, // R7 in range
    {8'd2,  1'b1, 1'b0, 32'h80000000, 16'h8000, 4'h0}  // R2 alt zero
  };

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_data;
  logic        alt_fmt;
  logic        dflt_nan;
  logic        out_valid;
  logic [15:0] out_data;
  logic        flag_invalid;
  logic        flag_overflow;
  logic        flag_underflow;
  logic        flag_inexact;

  int n_chk;
  int n_err;
  bit done;

  sp2hp_convert dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_data        (in_data),
    .alt_fmt        (alt_fmt),
    .dflt_nan       (dflt_nan),
    .out_valid      (out_valid),
    .out_data       (out_data),
    .flag_invalid   (flag_invalid),
    .flag_overflow  (flag_overflow),
    .flag_underflow (flag_underflow),
    .flag_inexact   (flag_inexact)
  );

  initial clk = 1'b0;
  always #(CLK_HALF) clk = ~clk;

  task automatic check(input int tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL R%0d %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic logic [3:0] flags_now();
    return {flag_invalid, flag_overflow, flag_underflow, flag_inexact};
  endfunction

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    n_chk    = 0;
    n_err    = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = 32'h0;
    alt_fmt  = 1'b0;
    dflt_nan = 1'b0;

    repeat (3) @(negedge clk);
    // R1 reset state while reset is held
    check(1, "valid in reset", 32'(out_valid), 32'h0);
    check(1, "data in reset", 32'(out_data), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(1, "valid after reset", 32'(out_valid), 32'h0);
    check(1, "flags after reset", 32'(flags_now()), 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      in_valid = 1'b1;
      alt_fmt  = VEC[i][53];
      dflt_nan = VEC[i][52];
      in_data  = VEC[i][51:20];
      @(negedge clk);
      in_valid = 1'b0;
      check(int'(VEC[i][61:54]), "result", 32'(out_data), 32'(VEC[i][19:4]));
      check(int'(VEC[i][61:54]), "flags", 32'(flags_now()), 32'(VEC[i][3:0]));
      check(1, "valid strobe", 32'(out_valid), 32'h1);
      @(negedge clk);
    end

    // R1 back-to-back operands, then an idle cycle that must not load
    alt_fmt  = 1'b0;
    dflt_nan = 1'b0;
    in_valid = 1'b1;
    in_data  = 32'h40000000;           // 2.0 -> 0x4000
    @(negedge clk);
    check(1, "b2b first", 32'(out_data), 32'h4000);
    in_data  = 32'h3F801001;           // -> 0x3C01 inexact
    @(negedge clk);
    check(1, "b2b second", 32'(out_data), 32'h3C01);
    check(1, "b2b valid", 32'(out_valid), 32'h1);
    in_valid = 1'b0;
    in_data  = 32'h7F800001;           // would raise invalid if loaded
    @(negedge clk);
    check(1, "idle valid low", 32'(out_valid), 32'h0);
    check(1, "idle data hold", 32'(out_data), 32'h3C01);
    check(1, "idle flags hold", 32'(flags_now()), 32'h1);
    @(negedge clk);
    check(1, "idle data hold 2", 32'(out_data), 32'h3C01);

    // R1 reset mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check(1, "reset clears data", 32'(out_data), 32'h0);
    check(1, "reset clears flags", 32'(flags_now()), 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    finish_run();
  end

endmodule